// File: doc/BRIEF.md
# Phase Lock Detector with Hysteresis

This block watches the two pulse outputs of a phase-frequency detector and decides whether the surrounding loop is in lock. A fast sampling clock runs the block. Each input first passes through a two-flop synchronizer. For every comparison cycle, the block counts the sampling periods during which exactly one of the two pulses is high. This count is the phase error of that cycle. It is taken when both pulses have returned low.

The lock flag is active high and has hysteresis. It rises only after a set number of back-to-back cycles whose error is below a lower threshold. Once high, it stays high while the errors stay at or below an upper threshold. A single cycle above that upper threshold drops it. Both thresholds and the run length are parameters, given in sampling periods. The lower threshold must be smaller than the upper one.

Top module: `lock_detect_hyst`

## Requirements
- R1: After reset (`rst_ni` low) `lock_o` is 0 and the run of good cycles is empty.
- R2: While unlocked, `lock_o` rises once `RUN_LEN` consecutive comparison cycles each have an error strictly below `LOCK_TH`.
- R3: While unlocked, a cycle with an error at or above `LOCK_TH` empties the run of good cycles, so `RUN_LEN` fresh good cycles are needed after it.
- R4: While locked, a cycle with an error at or below `UNLOCK_TH` leaves `lock_o` at 1.
- R5: While locked, one cycle with an error strictly above `UNLOCK_TH` clears `lock_o`.
- R6: A cycle's error is the number of sampling clocks in which exactly one of `up_i`/`dn_i` is high. Clocks with both high do not count. Either input may lead.
- R7: A cycle ends at the first clock edge that samples both inputs low. `lock_o` changes at the second rising edge after that edge.
- R8: After an unlock, relocking requires `RUN_LEN` new consecutive good cycles. Good cycles from before the unlock do not count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| up_i | input | 1 | Detector up pulse, asynchronous |
| dn_i | input | 1 | Detector down pulse, asynchronous |
| lock_o | output | 1 | Lock flag, active high |

## Verification
The assertions assume that every comparison cycle is separated from the next by at least one sampling clock with both pulses low. Without that gap, two detector cycles would merge into one measurement. The stimulus builds each cycle from a leading single-pulse stretch, an optional overlap with both pulses high, and an idle gap of several clocks. This keeps every case inside that assumption, including the cases where the error sits exactly on a threshold.

// File: rtl/lock_det_pkg.sv
package lock_det_pkg;
  // bits needed to hold values 0..max_val
  function automatic int bits_for(input int max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/phase_err_meter.sv
module phase_err_meter #(
  parameter int CNT_MAX = 8,
  localparam int CNT_W  = lock_det_pkg::bits_for(CNT_MAX)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             up_i,
  input  logic             dn_i,
  output logic             meas_vld_o,
  output logic [CNT_W-1:0] meas_err_o
);
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(CNT_MAX);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic             any_hi, one_hi;

  assign any_hi = up_i | dn_i;
  assign one_hi = up_i ^ dn_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= any_hi;
      if (busy_q && !any_hi)           cnt_q <= '0;
      else if (one_hi && cnt_q != CNT_LIM) cnt_q <= cnt_q + 1'b1; // saturate
    end
  end

  assign meas_vld_o = busy_q & ~any_hi;
  assign meas_err_o = cnt_q;

  // R6
  err_counts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (one_hi && cnt_q != CNT_LIM) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R6
  both_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_i && dn_i) |=> $stable(cnt_q));
endmodule

// File: rtl/lock_hyst_fsm.sv
module lock_hyst_fsm #(
  parameter int LOCK_TH   = 4,
  parameter int UNLOCK_TH = 7,
  parameter int RUN_LEN   = 3,
  parameter int CNT_W     = 4,
  localparam int GOOD_W   = lock_det_pkg::bits_for(RUN_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             meas_vld_i,
  input  logic [CNT_W-1:0] meas_err_i,
  output logic             lock_o
);
  localparam logic [CNT_W-1:0]  LOCK_V   = CNT_W'(LOCK_TH);
  localparam logic [CNT_W-1:0]  UNLOCK_V = CNT_W'(UNLOCK_TH);
  localparam logic [GOOD_W-1:0] LAST_V   = GOOD_W'(RUN_LEN - 1);

  logic              lock_q;
  logic [GOOD_W-1:0] good_q;
  logic              is_good, is_bad;

  assign is_good = meas_err_i < LOCK_V;
  assign is_bad  = meas_err_i > UNLOCK_V;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      good_q <= '0;
    end else if (meas_vld_i) begin
      if (lock_q) begin
        if (is_bad) begin
          lock_q <= 1'b0;
          good_q <= '0;
        end
      end else if (!is_good) begin
        good_q <= '0;
      end else if (good_q == LAST_V) begin
        lock_q <= 1'b1;
        good_q <= '0;
      end else begin
        good_q <= good_q + 1'b1;
      end
    end
  end

  assign lock_o = lock_q;

  // R2
  lock_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_q) |-> $past(meas_vld_i && meas_err_i < LOCK_V));

  // R3
  run_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock_q && meas_vld_i && meas_err_i >= LOCK_V) |=> (good_q == '0 && !lock_q));

  // R4
  hold_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && !(meas_vld_i && meas_err_i > UNLOCK_V)) |=> lock_q);

  // R5
  lock_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_q) |-> $past(meas_vld_i && meas_err_i > UNLOCK_V));

  // R8
  relock_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_q) |-> (good_q == '0));
endmodule

// File: rtl/lock_detect_hyst.sv
module lock_detect_hyst #(
  parameter int LOCK_TH   = 4,
  parameter int UNLOCK_TH = 7,
  parameter int RUN_LEN   = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic up_i,
  input  logic dn_i,
  output logic lock_o
);
  localparam int CNT_MAX = UNLOCK_TH + 1;
  localparam int CNT_W   = lock_det_pkg::bits_for(CNT_MAX);

  logic [1:0]       pd_s;
  logic             meas_vld;
  logic [CNT_W-1:0] meas_err;

  initial begin
    th_order_chk: assert (LOCK_TH < UNLOCK_TH && RUN_LEN >= 1);
  end

  bit_sync #(.WIDTH(2), .STAGES(2)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({up_i, dn_i}),
    .q_o   (pd_s)
  );

  phase_err_meter #(.CNT_MAX(CNT_MAX)) i_meter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .up_i      (pd_s[1]),
    .dn_i      (pd_s[0]),
    .meas_vld_o(meas_vld),
    .meas_err_o(meas_err)
  );

  lock_hyst_fsm #(
    .LOCK_TH  (LOCK_TH),
    .UNLOCK_TH(UNLOCK_TH),
    .RUN_LEN  (RUN_LEN),
    .CNT_W    (CNT_W)
  ) i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .meas_vld_i(meas_vld),
    .meas_err_i(meas_err),
    .lock_o    (lock_o)
  );
endmodule

// File: tb/test_lock_detect_hyst.sv
module test_lock_detect_hyst;
  localparam int LOCK_TH   = 4;
  localparam int UNLOCK_TH = 7;
  localparam int RUN_LEN   = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic up_i = 1'b0;
  logic dn_i = 1'b0;
  logic lock_o;

  int n_chk = 0;
  int n_fail = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  lock_detect_hyst #(.LOCK_TH(LOCK_TH), .UNLOCK_TH(UNLOCK_TH), .RUN_LEN(RUN_LEN))
    i_lock_detect_hyst (.clk_i(clk), .rst_ni(rst_ni), .up_i(up_i), .dn_i(dn_i), .lock_o(lock_o));

  // behavioural reference: input delay queue, burst width, run of good cycles
  bit [1:0] dly_q[$];
  bit       m_prev_any;
  int       m_acc, m_good;
  bit       m_lock;

  always @(posedge clk) begin
    bit [1:0] cur;
    if (!rst_ni) begin
      dly_q.delete();
      m_prev_any = 0; m_acc = 0; m_good = 0; m_lock = 0;
    end else begin
      dly_q.push_back({up_i, dn_i});
      cur = (dly_q.size() > 2) ? dly_q.pop_front() : 2'b00;
      if (m_prev_any && cur == 2'b00) begin
        if (m_lock) begin
          if (m_acc > UNLOCK_TH) begin m_lock = 0; m_good = 0; end
        end else if (m_acc < LOCK_TH) begin
          m_good++;
          if (m_good == RUN_LEN) begin m_lock = 1; m_good = 0; end
        end else m_good = 0;
        m_acc = 0;
      end
      if (cur[1] ^ cur[0]) m_acc++;
      m_prev_any = (cur != 2'b00);
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      n_chk++;
      if (lock_o !== m_lock) begin
        n_fail++;
        $display("FAIL %s: lock_o=%0b expected %0b at %0t", cur_req, lock_o, m_lock, $time);
      end
    end
  end

  task automatic check_lock(input string req, input bit exp);
    n_chk++;
    if (lock_o !== exp) begin
      n_fail++;
      $display("FAIL %s: lock_o=%0b expected %0b", req, lock_o, exp);
    end
  endtask

  // leading pulse alone for lead clocks, both high for ovl, then idle gap
  task automatic pd_cycle(input int lead, input int ovl, input bit dn_leads, input int gap = 6);
    for (int i = 0; i < lead; i++) begin
      @(negedge clk); up_i = !dn_leads; dn_i = dn_leads;
    end
    for (int i = 0; i < ovl; i++) begin
      @(negedge clk); up_i = 1; dn_i = 1;
    end
    @(negedge clk); up_i = 0; dn_i = 0;
    repeat (gap - 1) @(negedge clk);
  endtask

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    check_lock("R1", 1'b0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    check_lock("R1", 1'b0);

    // R3: a threshold-equal error breaks the run
    cur_req = "R3";
    pd_cycle(2, 1, 0); pd_cycle(3, 0, 0);
    pd_cycle(LOCK_TH, 1, 0);
    pd_cycle(1, 1, 0); pd_cycle(2, 0, 1);
    check_lock("R3", 1'b0);

    // R2/R7: third good cycle locks, exactly two edges after idle is sampled
    cur_req = "R2/R7";
    for (int i = 0; i < LOCK_TH - 1; i++) begin
      @(negedge clk); up_i = 1;
    end
    @(negedge clk); up_i = 0; // first idle sampled at next edge
    @(negedge clk); check_lock("R7", 1'b0);
    @(negedge clk); check_lock("R7", 1'b0);
    @(negedge clk); check_lock("R7", 1'b1);
    repeat (3) @(negedge clk);
    check_lock("R2", 1'b1);

    // R4: errors between thresholds, and equal to the upper one, keep lock
    cur_req = "R4";
    pd_cycle(LOCK_TH + 1, 0, 0);
    pd_cycle(UNLOCK_TH, 2, 1);
    check_lock("R4", 1'b1);

    // R6: overlap not counted; either lead
    cur_req = "R6";
    pd_cycle(UNLOCK_TH - 1, 5, 1);
    pd_cycle(1, 9, 0);
    check_lock("R6", 1'b1);

    // R5: single cycle just above the upper threshold unlocks
    cur_req = "R5";
    pd_cycle(UNLOCK_TH + 1, 1, 0);
    check_lock("R5", 1'b0);

    // R8: fresh run needed after unlock
    cur_req = "R8";
    pd_cycle(1, 1, 0); pd_cycle(0, 3, 0);
    check_lock("R8", 1'b0);
    pd_cycle(LOCK_TH - 1, 0, 1);
    check_lock("R8", 1'b1);
    pd_cycle(UNLOCK_TH + 4, 0, 1);
    check_lock("R5", 1'b0);
    pd_cycle(1, 0, 0); pd_cycle(1, 0, 0); pd_cycle(1, 0, 0);
    check_lock("R8", 1'b1);

    // R1: reset while locked
    cur_req = "R1";
    rst_ni = 1'b0;
    @(negedge clk); check_lock("R1", 1'b0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    check_lock("R1", 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule